// File: doc/BRIEF.md
# Program Flash Region Access Guard

This block decides, request by request, whether an access to program flash may go ahead. The flash word address space has three parts. The application region sits at the bottom. A table region forms the upper part of the application area. The boot region sits above both. Each of the three regions has two lock bits of its own. One blocks writes only. The other blocks both reads and writes.

A request carries four things: the target address, a write/read flag, the address of the instruction that issued it, and the current lock settings. The guard answers in the same cycle with a grant. It also applies a self-programming rule: a write aimed at the application area, including its table part, only goes ahead when the issuing instruction itself lies in the boot region. A denied request raises a registered error flag for exactly one cycle on the following clock.

The guard holds no lock state of its own. The flash array, its timing and the way lock bits get programmed all live elsewhere.

Top module: `pmem_guard`

## Requirements
- R1: With the default parameters (12-bit word address, table base 0xC00, boot base 0xE00), addresses below 0xC00 fall in the application region, 0xC00 to 0xDFF in the table region, and 0xE00 and above in the boot region. The same boundaries classify `issuer_addr`.
- R2: `lock_bits` encoding: bit 0 is the application write lock, bit 1 the application read/write lock, bit 2 the table write lock, bit 3 the table read/write lock, bit 4 the boot write lock, bit 5 the boot read/write lock. A set bit means locked.
- R3: A read is denied exactly when the read/write lock of the target region is set. The write lock has no effect on reads.
- R4: A write is denied when the target region's write lock or its read/write lock is set.
- R5: For table addresses only the table lock bits count. The application lock bits have no effect there.
- R6: A write whose target lies in the application or table region is denied unless `issuer_addr` lies in the boot region, whatever the lock bits are.
- R7: A write to the boot region is judged on the boot lock bits alone. The issuer location has no effect on it.
- R8: `grant` is combinational and valid in the same cycle as the request. It is low whenever `req_valid` is low.
- R9: `err` is high in the cycle after a valid request that was denied, and low after any granted or idle cycle. It is 0 during reset.
- R10: The boot lock bits have no effect on accesses to the application or table regions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write (self-programming store), 0 = read |
| req_addr | input | ADDR_W | Target flash word address |
| issuer_addr | input | ADDR_W | Address of the instruction issuing the request |
| lock_bits | input | 6 | Region lock settings, encoding per R2 |
| grant | output | 1 | Request allowed |
| err | output | 1 | One-cycle flag for a denied request |

## Verification
Two different causes of denial can fall on the same write. One is a region lock. The other is the self-programming rule, which applies when an application-area write comes from outside the boot region. The bench drives writes where only one cause holds and writes where both hold, and in each case judges `grant` and the error flag against the rule. A second kind of overlap is the error flag of one request sharing a cycle with the grant of the next. The bench provokes this with back-to-back requests, a denied one followed by a granted one. It then checks that the flag reports the earlier request while `grant` reports the later one.

// File: rtl/pmem_guard_pkg.sv
package pmem_guard_pkg;
  typedef enum logic [1:0] {
    RGN_APP  = 2'd0,
    RGN_TBL  = 2'd1,
    RGN_BOOT = 2'd2
  } region_e;

  typedef struct packed {
    logic rw;
    logic wr;
  } lock_pair_t;

  localparam int NUM_RGN = 3;
  localparam int LOCK_W  = 2 * NUM_RGN;
endpackage

// File: rtl/pmem_region_decode.sv
module pmem_region_decode
  import pmem_guard_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int TBL_BASE  = 'hC00,
  parameter int BOOT_BASE = 'hE00
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam logic [ADDR_W-1:0] TBL_A  = TBL_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] BOOT_A = BOOT_BASE[ADDR_W-1:0];

  always_comb begin
    if (addr >= BOOT_A)      region = RGN_BOOT;
    else if (addr >= TBL_A)  region = RGN_TBL;
    else                     region = RGN_APP;
  end
endmodule

// File: rtl/pmem_lock_eval.sv
module pmem_lock_eval
  import pmem_guard_pkg::*;
(
  input  region_e           tgt_rgn,
  input  region_e           src_rgn,
  input  logic              is_write,
  input  logic [LOCK_W-1:0] lock_bits,
  output logic              allowed
);
  lock_pair_t pair [NUM_RGN];
  lock_pair_t sel;
  logic       lock_deny;
  logic       self_prog_deny;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_pair
    assign pair[g].wr = lock_bits[2*g];
    assign pair[g].rw = lock_bits[2*g+1];
  end

  always_comb begin
    unique case (tgt_rgn)
      RGN_TBL:  sel = pair[1];
      RGN_BOOT: sel = pair[2];
      default:  sel = pair[0];
    endcase
  end

  always_comb begin
    lock_deny      = is_write ? (sel.wr | sel.rw) : sel.rw;
    self_prog_deny = is_write && (tgt_rgn != RGN_BOOT) && (src_rgn != RGN_BOOT);
    allowed        = !lock_deny && !self_prog_deny;
  end
endmodule

// File: rtl/pmem_guard.sv
module pmem_guard
  import pmem_guard_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int TBL_BASE  = 'hC00,
  parameter int BOOT_BASE = 'hE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] issuer_addr,
  input  logic [LOCK_W-1:0] lock_bits,
  output logic              grant,
  output logic              err
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [ADDR_W-1:0] dec_addr [2];
  region_e           dec_rgn  [2];
  logic              allowed;
  logic              err_d;
  logic              err_q;
  logic              err_en;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign dec_addr[0] = req_addr;
  assign dec_addr[1] = issuer_addr;

  for (genvar i = 0; i < 2; i++) begin : g_dec
    pmem_region_decode #(
      .ADDR_W   (ADDR_W),
      .TBL_BASE (TBL_BASE),
      .BOOT_BASE(BOOT_BASE)
    ) u_dec (
      .addr  (dec_addr[i]),
      .region(dec_rgn[i])
    );
  end

  pmem_lock_eval u_eval (
    .tgt_rgn  (dec_rgn[0]),
    .src_rgn  (dec_rgn[1]),
    .is_write (req_write),
    .lock_bits(lock_bits),
    .allowed  (allowed)
  );

  assign grant  = req_valid && allowed;
  assign err_en = 1'b1;

  always_comb begin
    err_d = req_valid && !allowed;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign err = err_q;
endmodule

// File: rtl/pmem_guard_chk.sv
module pmem_guard_chk
  import pmem_guard_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int TBL_BASE  = 'hC00,
  parameter int BOOT_BASE = 'hE00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] issuer_addr,
  input logic [LOCK_W-1:0] lock_bits,
  input logic              grant,
  input logic              err
);
  localparam logic [ADDR_W-1:0] TBL_A  = TBL_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] BOOT_A = BOOT_BASE[ADDR_W-1:0];

  logic [1:0] armed_cnt;
  logic       armed;
  logic       in_tbl;
  logic       in_boot;
  logic       src_boot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_cnt <= 2'd0;
    else if (!armed)    armed_cnt <= armed_cnt + 2'd1;
  end
  assign armed    = (armed_cnt == 2'd3);
  assign in_boot  = req_addr >= BOOT_A;
  assign in_tbl   = (req_addr >= TBL_A) && !in_boot;
  assign src_boot = issuer_addr >= BOOT_A;

  // R8
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !grant);

  // R9
  deny_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && req_valid && !grant) |=> err);

  // R9
  err_only_after_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !grant) |=> !err);

  // R6
  self_prog_outside_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !in_boot && !src_boot) |-> !grant);

  // R5
  tbl_rw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_tbl && lock_bits[3]) |-> !grant);

  // R3
  open_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && lock_bits == '0) |-> grant);
endmodule

bind pmem_guard pmem_guard_chk #(
  .ADDR_W   (ADDR_W),
  .TBL_BASE (TBL_BASE),
  .BOOT_BASE(BOOT_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .issuer_addr(issuer_addr),
  .lock_bits  (lock_bits),
  .grant      (grant),
  .err        (err)
);

// File: tb/sim_pmem_guard.sv
module sim_pmem_guard;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [11:0] req_addr;
  logic [11:0] issuer_addr;
  logic [5:0]  lock_bits;
  logic        grant;
  logic        err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [11:0] A_APP  = 12'h100;
  localparam logic [11:0] A_APPT = 12'hBFF;
  localparam logic [11:0] A_TBL  = 12'hC00;
  localparam logic [11:0] A_TBLT = 12'hDFF;
  localparam logic [11:0] A_BOOT = 12'hE00;
  localparam logic [11:0] A_TOP  = 12'hFFF;

  pmem_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .issuer_addr(issuer_addr), .lock_bits(lock_bits),
    .grant(grant), .err(err)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one request: grant checked in the same cycle, err one edge later
  task automatic access(input bit wr, input logic [11:0] addr, input logic [11:0] src,
                        input logic [5:0] locks, input bit exp_grant, input string req);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; issuer_addr = src; lock_bits = locks;
    #1 check(grant == exp_grant, {req, " grant"}, grant, exp_grant);
    @(negedge clk);
    check(err == !exp_grant, {req, " err"}, err, !exp_grant);
    req_valid = 0;
  endtask

  task automatic t_reset;
    check(err == 0, "R9 reset err", err, 0);
    check(grant == 0, "R8 reset grant", grant, 0);
  endtask

  task automatic t_regions_read;
    access(0, A_APPT, A_APP, 6'b000010, 0, "R1 R3 app top rw-lock");
    access(0, A_TBL,  A_APP, 6'b000010, 1, "R1 R5 tbl base ignores app lock");
    access(0, A_TBLT, A_APP, 6'b001000, 0, "R1 R3 tbl top rw-lock");
    access(0, A_BOOT, A_APP, 6'b001000, 1, "R1 boot base not tbl");
    access(0, A_TOP,  A_APP, 6'b100000, 0, "R2 R3 boot rw-lock");
  endtask

  task automatic t_read_wr_lock;
    access(0, A_APP,  A_APP, 6'b000001, 1, "R3 app wr lock no effect on read");
    access(0, A_TBL,  A_APP, 6'b000100, 1, "R3 tbl wr lock no effect on read");
    access(0, A_BOOT, A_BOOT, 6'b010000, 1, "R3 boot wr lock no effect on read");
  endtask

  task automatic t_writes;
    access(1, A_APP,  A_BOOT, 6'b000000, 1, "R4 app write open");
    access(1, A_APP,  A_BOOT, 6'b000001, 0, "R4 app wr lock");
    access(1, A_APP,  A_BOOT, 6'b000010, 0, "R4 app rw lock");
    access(1, A_BOOT, A_BOOT, 6'b010000, 0, "R4 boot wr lock");
  endtask

  task automatic t_table;
    access(1, A_TBL,  A_BOOT, 6'b000011, 1, "R5 app locks ignored in tbl");
    access(1, A_TBLT, A_BOOT, 6'b000100, 0, "R5 tbl wr lock");
    access(1, A_APP,  A_BOOT, 6'b001100, 1, "R5 tbl locks ignored in app");
  endtask

  task automatic t_self_prog;
    access(1, A_APP,  A_APP,  6'b000000, 0, "R6 app write from app");
    access(1, A_TBL,  A_TBLT, 6'b000000, 0, "R6 tbl write from tbl");
    access(1, A_APP,  A_TOP,  6'b000000, 1, "R6 app write from boot top");
    access(1, A_APP,  A_APP,  6'b000001, 0, "R6 R4 both causes");
  endtask

  task automatic t_boot;
    access(1, A_BOOT, A_APP, 6'b000000, 1, "R7 boot write from app");
    access(1, A_TOP,  A_TBL, 6'b001111, 1, "R7 R10 other locks ignored");
    access(0, A_APP,  A_APP, 6'b110000, 1, "R10 boot locks ignored in app");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = A_APP; issuer_addr = A_APP; lock_bits = 0;
    #1 check(grant == 0, "R9 b2b first grant", grant, 0);
    @(negedge clk);
    req_write = 0;
    #1 check(grant == 1, "R9 b2b second grant", grant, 1);
    check(err == 1, "R9 b2b err of first", err, 1);
    @(negedge clk);
    req_valid = 0;
    check(err == 0, "R9 b2b err after grant", err, 0);
    #1 check(grant == 0, "R8 idle grant", grant, 0);
    @(negedge clk);
    check(err == 0, "R9 err after idle", err, 0);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; issuer_addr = 0; lock_bits = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_regions_read;
    t_read_wr_lock;
    t_writes;
    t_table;
    t_self_prog;
    t_boot;
    t_back_to_back;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule